// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt sources into groups and tells the CPU which priority level to service. Each group holds a small vector of pending request bits, a vector of enable bits and a priority level. Group 0 is non-maskable: its enables are forced on and its level is fixed at zero. The remaining groups are level groups whose enables and level are programmed over a byte-wide register bus. Source requests arrive already latched as one-cycle set pulses; software clears them by writing ones.

Every cycle an arbiter picks the active group (one with a request bit that is also enabled) having the smallest level value, and the controller registers that level onto the CPU level output. A small two-state machine tracks whether anything is being driven. `ST_IDLE` means no group is active and the output shows the idle code. `ST_DRIVE` means a group is selected. Its transitions are `ARM` (idle to drive when a group becomes active), `RESELECT` (drive to drive when the winning group or its level changes), `RELEASE` (drive to idle when no group remains active) and `HOLD` (no change). Every transition except `HOLD` raises a one-cycle update strobe. The group that was selected last is kept as the accepted group, which software can read back. That readback returns zero once the accepted group has lost all of its enabled requests.

Top module: `grp_prio_intc`

## Requirements
- R1: After reset the CPU level is all ones (7), the update strobe is low, every pending and enable bit is zero, every level-group level is all ones, and the trigger register is zero.
- R2: A 1 on source bit g*4+b sets pending bit b of group g, and the pending bit stays set until software clears it. A write to group g control byte 0 clears a pending bit where the written bit is 1: bits [7:4] for a level group, bits [3:0] for the non-maskable group 0. A set and a clear in the same cycle leave the bit set.
- R3: The selected group is the active group with the numerically lowest level. On equal levels the lower group number wins. Group 0 always has level 0 and all enables on.
- R4: The CPU level output takes the selected group's level one cycle after the pending, enable and level state change, and shows 7 when no group is active. The update strobe is high for exactly the cycles in which the output was re-driven.
- R5: A read of address 0x00 returns the accepted group number shifted left by 2 when that group still has an enabled pending bit, and returns 0 otherwise. The accepted group follows the selection one cycle after the selection changes.
- R6: A read of address 0x01 returns 0, and a read of any unmapped address returns 0.
- R7: Group 0 control byte 0 (0x10) returns its pending bits in [3:0] with [7:4] zero. Its byte 1 (0x11) reads 0, and writes to byte 1 change nothing.
- R8: Level group g control byte 0 (address 0x10+2g) returns pending bits in [7:4] and pending AND enable in [3:0].
- R9: Level group g control byte 1 (address 0x11+2g) returns the level in [6:4] and the enables in [3:0]. A write to it loads both fields.
- R10: Address 0x08 is the trigger register. It holds 2 trigger bits each for groups 4 to 7, with group 4+k at bits [2k+1:2k]. A read returns the value last written.
- R11: Read data is registered. It appears on the cycle after the read strobe and is 0 on every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Latched request set pulses, 4 bits per group |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_level | output | 3 | Priority level driven to the CPU, 7 when idle |
| cpu_level_upd | output | 1 | One-cycle pulse when the level output is re-driven |

## Verification
The hardest case to reach is the accepted-group read that returns zero while another group is still pending. This read has to land in the single cycle after the accepted group's request was cleared and before the accepted group moves on to the next winner. The bench issues the clearing write and the read on back-to-back cycles, so the read samples the cleared pending state against the stale accepted group. A second read a few cycles later then shows the new winner. Equal-level ties, masked requests that stay out of the detect field, and an ignored write to the non-maskable group's byte 1 are each set up explicitly and observed at the ports.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } intc_state_e;

    localparam logic [7:0] ADDR_ACC      = 8'h00;
    localparam logic [7:0] ADDR_ACC_HI   = 8'h01;
    localparam logic [7:0] ADDR_TRIG     = 8'h08;
    localparam int         CTL_BASE      = 16;
    localparam int         TRIG_GROUPS   = 4;
    localparam int         TRIG_W        = 2;
    localparam int         REQ_FIELD_LSB = 4;
    localparam int         LVL_FIELD_LSB = 4;

endpackage

// File: rtl/ic_group_bank.sv
module ic_group_bank
    import grp_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int REQ_W      = 4,
    parameter int LVL_W      = 3,
    parameter int NMI_GROUPS = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*REQ_W-1:0] src_req,
    input  logic                        wr_en,
    input  logic [7:0]                  wr_addr,
    input  logic [7:0]                  wr_data,
    output logic [NUM_GROUPS*REQ_W-1:0] pend_flat,
    output logic [NUM_GROUPS*REQ_W-1:0] en_flat,
    output logic [NUM_GROUPS*LVL_W-1:0] lvl_flat
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [7:0] A_B0 = 8'(CTL_BASE + 2*g);
        localparam logic [7:0] A_B1 = 8'(CTL_BASE + 2*g + 1);

        logic             hit_b0;
        logic             hit_b1;
        logic [REQ_W-1:0] clr;
        logic [REQ_W-1:0] pend_q;

        assign hit_b0 = wr_en && (wr_addr == A_B0);
        assign hit_b1 = wr_en && (wr_addr == A_B1);

        if (g < NMI_GROUPS) begin : g_nmi
            assign clr = hit_b0 ? wr_data[REQ_W-1:0] : '0;
            assign en_flat[g*REQ_W +: REQ_W]  = '1;
            assign lvl_flat[g*LVL_W +: LVL_W] = '0;
        end else begin : g_lvl
            logic [REQ_W-1:0] en_q;
            logic [LVL_W-1:0] lvl_q;

            assign clr = hit_b0 ? wr_data[REQ_FIELD_LSB +: REQ_W] : '0;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q  <= '0;
                    lvl_q <= '1;
                end else if (hit_b1) begin
                    en_q  <= wr_data[REQ_W-1:0];
                    lvl_q <= wr_data[LVL_FIELD_LSB +: LVL_W];
                end
            end

            assign en_flat[g*REQ_W +: REQ_W]  = en_q;
            assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else begin
                pend_q <= (pend_q & ~clr) | src_req[g*REQ_W +: REQ_W];
            end
        end

        assign pend_flat[g*REQ_W +: REQ_W] = pend_q;
    end

endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
    parameter int NUM_GROUPS = 8,
    parameter int REQ_W      = 4,
    parameter int LVL_W      = 3,
    localparam int GW        = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS*REQ_W-1:0] pend_flat,
    input  logic [NUM_GROUPS*REQ_W-1:0] en_flat,
    input  logic [NUM_GROUPS*LVL_W-1:0] lvl_flat,
    output logic                        any_active,
    output logic [GW-1:0]               win_grp,
    output logic [LVL_W-1:0]            win_lvl
);

    logic [NUM_GROUPS-1:0] grp_active;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_act
        assign grp_active[g] = |(pend_flat[g*REQ_W +: REQ_W] & en_flat[g*REQ_W +: REQ_W]);
    end

    // Strict less-than keeps the lower group number on equal levels.
    always_comb begin
        any_active = 1'b0;
        win_grp    = '0;
        win_lvl    = '1;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_active[g] && (!any_active || (lvl_flat[g*LVL_W +: LVL_W] < win_lvl))) begin
                any_active = 1'b1;
                win_grp    = GW'(g);
                win_lvl    = lvl_flat[g*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/ic_read_mux.sv
module ic_read_mux
    import grp_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int REQ_W      = 4,
    parameter int LVL_W      = 3,
    parameter int NMI_GROUPS = 1,
    localparam int GW        = $clog2(NUM_GROUPS),
    localparam int TRIG_BITS = TRIG_GROUPS * TRIG_W
) (
    input  logic [7:0]                  rd_addr,
    input  logic [NUM_GROUPS*REQ_W-1:0] pend_flat,
    input  logic [NUM_GROUPS*REQ_W-1:0] en_flat,
    input  logic [NUM_GROUPS*LVL_W-1:0] lvl_flat,
    input  logic [GW-1:0]               acc_grp,
    input  logic [TRIG_BITS-1:0]        trig_mode,
    output logic [7:0]                  rd_val
);

    logic [7:0] ctl_b0 [NUM_GROUPS];
    logic [7:0] ctl_b1 [NUM_GROUPS];
    logic       acc_live;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_view
        logic [REQ_W-1:0] p;
        logic [REQ_W-1:0] e;
        assign p = pend_flat[g*REQ_W +: REQ_W];
        assign e = en_flat[g*REQ_W +: REQ_W];
        if (g < NMI_GROUPS) begin : g_nmi
            assign ctl_b0[g] = 8'(p);
            assign ctl_b1[g] = 8'h00;
        end else begin : g_lvl
            assign ctl_b0[g] = (8'(p) << REQ_FIELD_LSB) | 8'(p & e);
            assign ctl_b1[g] = (8'(lvl_flat[g*LVL_W +: LVL_W]) << LVL_FIELD_LSB) | 8'(e);
        end
    end

    assign acc_live = |(pend_flat[acc_grp*REQ_W +: REQ_W] & en_flat[acc_grp*REQ_W +: REQ_W]);

    always_comb begin
        rd_val = 8'h00;
        if (rd_addr == ADDR_ACC) begin
            if (acc_live) begin
                rd_val = 8'(acc_grp) << 2;
            end
        end else if (rd_addr == ADDR_ACC_HI) begin
            rd_val = 8'h00;
        end else if (rd_addr == ADDR_TRIG) begin
            rd_val = 8'(trig_mode);
        end else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (rd_addr == 8'(CTL_BASE + 2*g)) begin
                    rd_val = ctl_b0[g];
                end
                if (rd_addr == 8'(CTL_BASE + 2*g + 1)) begin
                    rd_val = ctl_b1[g];
                end
            end
        end
    end

endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc
    import grp_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int REQ_W      = 4,
    parameter int LVL_W      = 3,
    parameter int NMI_GROUPS = 1,
    localparam int GW        = $clog2(NUM_GROUPS),
    localparam int SRC_W     = NUM_GROUPS * REQ_W,
    localparam int TRIG_BITS = TRIG_GROUPS * TRIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_req,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [LVL_W-1:0] cpu_level,
    output logic             cpu_level_upd
);

    logic [SRC_W-1:0]            pend_flat;
    logic [SRC_W-1:0]            en_flat;
    logic [NUM_GROUPS*LVL_W-1:0] lvl_flat;
    logic                        any_active;
    logic [GW-1:0]               win_grp;
    logic [LVL_W-1:0]            win_lvl;
    logic [GW-1:0]               acc_grp;
    logic [TRIG_BITS-1:0]        trig_mode;
    logic [7:0]                  rd_val;
    intc_state_e                 state_q;
    intc_state_e                 state_nx;
    logic                        redrive;

    ic_group_bank #(
        .NUM_GROUPS(NUM_GROUPS), .REQ_W(REQ_W), .LVL_W(LVL_W), .NMI_GROUPS(NMI_GROUPS)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .pend_flat(pend_flat), .en_flat(en_flat), .lvl_flat(lvl_flat)
    );

    ic_arbiter #(
        .NUM_GROUPS(NUM_GROUPS), .REQ_W(REQ_W), .LVL_W(LVL_W)
    ) u_arb (
        .pend_flat(pend_flat), .en_flat(en_flat), .lvl_flat(lvl_flat),
        .any_active(any_active), .win_grp(win_grp), .win_lvl(win_lvl)
    );

    ic_read_mux #(
        .NUM_GROUPS(NUM_GROUPS), .REQ_W(REQ_W), .LVL_W(LVL_W), .NMI_GROUPS(NMI_GROUPS)
    ) u_rmux (
        .rd_addr(bus_addr), .pend_flat(pend_flat), .en_flat(en_flat),
        .lvl_flat(lvl_flat), .acc_grp(acc_grp), .trig_mode(trig_mode),
        .rd_val(rd_val)
    );

    // Trigger-mode register: stored and returned, packed 2 bits per group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_mode <= '0;
        end else if (bus_wr && (bus_addr == ADDR_TRIG)) begin
            trig_mode <= bus_wdata[TRIG_BITS-1:0];
        end
    end

    // Registered read data, zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
        end else begin
            bus_rdata <= bus_rd ? rd_val : 8'h00;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: ARM, RESELECT, RELEASE, HOLD.
    always_comb begin
        state_nx = state_q;
        redrive  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_active) begin
                    state_nx = ST_DRIVE;
                    redrive  = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (!any_active) begin
                    state_nx = ST_IDLE;
                    redrive  = 1'b1;
                end else if ((win_grp != acc_grp) || (win_lvl != cpu_level)) begin
                    redrive = 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_level     <= '1;
            cpu_level_upd <= 1'b0;
            acc_grp       <= '0;
        end else begin
            cpu_level_upd <= redrive;
            if (redrive) begin
                cpu_level <= any_active ? win_lvl : '1;
            end
            if (any_active) begin
                acc_grp <= win_grp;
            end
        end
    end

endmodule

// File: rtl/grp_prio_intc_chk.sv
module grp_prio_intc_chk #(
    parameter int REQ_W = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cpu_level,
    input logic             cpu_level_upd,
    input logic             bus_rd,
    input logic [7:0]       bus_rdata,
    input logic [REQ_W-1:0] nmi_pend,
    input logic             any_active
);

    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level != $past(cpu_level)) |-> cpu_level_upd); // R4

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !any_active |=> (cpu_level == '1)); // R4

    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend != '0) |=> (cpu_level == '0)); // R3

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 8'h00)); // R11

    AST_UPD_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level_upd && $stable(cpu_level)) |-> any_active || (cpu_level == '1)); // R4

endmodule

bind grp_prio_intc grp_prio_intc_chk #(
    .REQ_W(REQ_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_level(cpu_level), .cpu_level_upd(cpu_level_upd),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .nmi_pend(pend_flat[REQ_W-1:0]),
    .any_active(any_active)
);

// File: tb/grp_prio_intc_tb.sv
`timescale 1ns/1ps
module grp_prio_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  cpu_level;
    logic        cpu_level_upd;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;
    logic rd_q   = 1'b0;

    logic [7:0] q_exp [$];
    string      q_tag [$];

    always #2.5 clk = ~clk;

    grp_prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_level(cpu_level), .cpu_level_upd(cpu_level_upd)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Driver tasks: called at a falling edge, return at the next one.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        src_req = v;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops one expected byte for each read issued.
    always @(posedge clk) rd_q <= bus_rd;

    always @(negedge clk) begin
        if (rd_q) begin
            if (q_exp.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R11 unexpected read data actual=0x%0h expected=none", bus_rdata);
            end else begin
                check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 level", cpu_level, 7);
        check("R1 upd", cpu_level_upd, 0);
        check("R11 quiet rdata", bus_rdata, 0);
        rd_exp(8'h13, 8'h70, "R1 g1 byte1");
        rd_exp(8'h08, 8'h00, "R1 trig");
        rd_exp(8'h00, 8'h00, "R5 acc idle");

        // Configure: g1 lvl3 en F, g2 lvl3 en 1, g3 lvl1 en 2
        wr(8'h13, 8'h3F);
        wr(8'h15, 8'h31);
        wr(8'h17, 8'h12);
        rd_exp(8'h13, 8'h3F, "R9 g1 byte1");

        // R2/R4: g1 bit0
        pulse(32'h0000_0010);
        check("R4 level before", cpu_level, 7);
        idle(1);
        check("R4 level g1", cpu_level, 3);
        check("R4 upd pulse", cpu_level_upd, 1);
        idle(1);
        check("R4 upd drop", cpu_level_upd, 0);
        rd_exp(8'h00, 8'h04, "R5 acc g1");
        rd_exp(8'h12, 8'h11, "R8 g1 byte0");

        // R3 tie: g2 same level, g1 keeps it
        pulse(32'h0000_0100);
        idle(2);
        check("R3 tie level", cpu_level, 3);
        rd_exp(8'h00, 8'h04, "R3 tie lower group");

        // R3: g3 bit1 enabled, level 1 wins
        pulse(32'h0000_2000);
        idle(2);
        check("R3 lower level wins", cpu_level, 1);
        rd_exp(8'h00, 8'h0C, "R5 acc g3");

        // R8 masked bit: g2 bit1 not enabled
        pulse(32'h0000_0200);
        idle(1);
        rd_exp(8'h14, 8'h31, "R8 g2 masked detect");
        check("R3 masked no effect", cpu_level, 1);

        // R2 clear g3 -> back to g1
        wr(8'h16, 8'h20);
        idle(2);
        check("R2 clear g3 level", cpu_level, 3);
        rd_exp(8'h16, 8'h00, "R2 g3 cleared");
        rd_exp(8'h00, 8'h04, "R5 acc back to g1");

        // R5 vanish: clear g1, read on the very next cycle
        wr(8'h12, 8'h10);
        rd_exp(8'h00, 8'h00, "R5 vanished accepted");
        idle(2);
        rd_exp(8'h00, 8'h08, "R5 acc moves to g2");
        check("R4 level g2", cpu_level, 3);

        // R7 non-maskable group
        pulse(32'h0000_0001);
        idle(1);
        check("R3 nmi level", cpu_level, 0);
        rd_exp(8'h10, 8'h01, "R7 nmi byte0");
        rd_exp(8'h11, 8'h00, "R7 nmi byte1");
        wr(8'h11, 8'h00);
        idle(2);
        check("R7 nmi byte1 write ignored", cpu_level, 0);
        wr(8'h10, 8'h01);
        idle(2);
        check("R2 nmi clear", cpu_level, 3);

        // R9/R4 level rewrite on the selected group
        wr(8'h15, 8'h51);
        idle(1);
        check("R4 redrive on level write", cpu_level, 5);
        check("R4 redrive upd", cpu_level_upd, 1);
        rd_exp(8'h15, 8'h51, "R9 g2 byte1");

        // R2 set wins over clear in the same cycle
        src_req = 32'h0000_0400;
        wr(8'h14, 8'h40);
        src_req = '0;
        rd_exp(8'h14, 8'h71, "R2 set beats clear");

        // Release everything
        wr(8'h14, 8'hF0);
        idle(2);
        check("R4 idle code", cpu_level, 7);
        rd_exp(8'h00, 8'h00, "R5 acc no request");

        // R10 trigger packing, R6 zero reads
        wr(8'h08, 8'hB4);
        rd_exp(8'h08, 8'hB4, "R10 trig readback");
        wr(8'h08, 8'h0C);
        rd_exp(8'h08, 8'h0C, "R10 group5 field");
        rd_exp(8'h01, 8'h00, "R6 acc byte1");
        rd_exp(8'h30, 8'h00, "R6 unmapped");

        idle(3);
        check("R11 scoreboard drained", q_exp.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule